// File: doc/BRIEF.md
# External Code Fetch Strobe Sequencer

This block drives the off-chip program memory bus of an 8-bit controller core. It divides the oscillator clock into machine cycles of twelve periods, each split into two fetch slots of six periods. For an external fetch the slot puts the low address byte on a shared port and pulses the address latch strobe, which an external latch captures on its falling edge. It then holds the address for one more period, releases the shared port, and lowers the active-low program store strobe for three periods. The byte the memory returns is sampled at the end of the last strobe-low period.

The high address byte sits on a dedicated port for the whole slot. A mode pin selects where code comes from. With the pin high, the lowest 4 KB are served on chip and produce no bus activity. With the pin low, every fetch goes off chip. The core presents a fetch address and a request, and these are sampled once per slot.

Top module: `xfs_fetch_seq`

## Requirements
- R1: While `rst` is high, and until the first slot with an external fetch, `ale`=0, `psen_n`=1, `port_lo_out`=8'hFF, `port_lo_oe`=0, `port_hi_out`=8'hFF, `code_valid`=0 and `code_byte`=8'h00.
- R2: Slots are 6 clock periods long, two per 12-period machine cycle. `fetch_req`, `fetch_addr` and `ea_pin` are sampled at the rising edge that ends the 6th, 12th, 18th… period counted from reset release. The slot they select fills the next 6 periods.
- R3: In an external slot `ale` is high in periods 1–2 and low in periods 3–6.
- R4: In an external slot `port_lo_out` carries `fetch_addr[7:0]`. `port_lo_oe` is high in periods 1–3 (two latch periods plus one hold period) and low in periods 4–6.
- R5: In an external slot `psen_n` is low in periods 4–6 and high in periods 1–3. `psen_n` is never low while `ale` is high.
- R6: In an external slot `port_hi_out` carries `fetch_addr[15:8]` in all six periods. Outside external slots it is 8'hFF.
- R7: With `ea_pin`=1, a requested address from 16'h0000 to 16'h0FFF is an internal fetch. Its slot shows the idle values of R1 on every output, and `code_byte` is unchanged. Addresses from 16'h1000 up are external.
- R8: With `ea_pin`=0, every requested address, including 16'h0000–16'h0FFF, is an external fetch.
- R9: At the edge that ends period 6 of an external slot, `port_lo_in` is stored into `code_byte`, and `code_valid` is high for exactly the following clock. `code_byte` keeps its value otherwise, and `port_lo_in` at any other time has no effect.
- R10: A slot whose sampled `fetch_req` is 0 is idle: all outputs take the R1 idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ea_pin | input | 1 | 1: low 4 KB on chip; 0: all code off chip |
| fetch_addr | input | 16 | Code address of the next fetch |
| fetch_req | input | 1 | Fetch wanted in the next slot |
| port_lo_in | input | 8 | Shared low port, input side (instruction data) |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store strobe, active low |
| port_lo_out | output | 8 | Shared low port, output side (low address) |
| port_lo_oe | output | 1 | Output enable of the shared low port |
| port_hi_out | output | 8 | High address byte |
| code_byte | output | 8 | Last captured instruction byte |
| code_valid | output | 1 | One-clock pulse with each captured byte |

## Verification
The bench targets the on-chip boundary at 16'h0FFF/16'h1000 under both mode-pin values. A wrong compare there would strobe the bus for an on-chip address, or leave an off-chip one silent. It runs back-to-back external slots, where an off-by-one in the slot counter or the strobe decode would shift `ale` or `psen_n` by a period or merge two strobes. It also randomizes `port_lo_in` every period, so sampling at any period other than the last strobe-low one, or capturing during internal or idle slots, shows up as a wrong `code_byte`.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    // Where a period sits inside a fetch slot
    typedef enum logic [1:0] {
        PH_LATCH  = 2'd0,   // address latch strobe high
        PH_HOLD   = 2'd1,   // address held after latch strobe falls
        PH_STROBE = 2'd2    // program store strobe low, port released
    } slot_phase_e;

    // What the current slot does
    typedef struct packed {
        logic              ext;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    function automatic slot_phase_e phase_of(input int unsigned sub,
                                             input int unsigned latch_len,
                                             input int unsigned hold_len);
        if (sub < latch_len)
            return PH_LATCH;
        else if (sub < latch_len + hold_len)
            return PH_HOLD;
        else
            return PH_STROBE;
    endfunction

endpackage

// File: rtl/xfs_slot_timer.sv
module xfs_slot_timer #(
    parameter int SLOT_LEN = 6,
    localparam int SUB_W   = $clog2(SLOT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SUB_W-1:0] sub,
    output logic             slot_end
);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(SLOT_LEN - 1);

    assign slot_end = (sub == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            sub <= '0;
        else if (slot_end)
            sub <= '0;
        else
            sub <= sub + 1'b1;
    end

    // R2: a slot always wraps to its first period after the last one
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (sub == LAST) |=> (sub == '0));

endmodule

// File: rtl/xfs_route.sv
module xfs_route #(
    parameter int ADDR_W        = 16,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] addr,
    output logic              ext
);
    generate
        if (INT_ROM_BYTES == 0) begin : g_no_rom
            // No on-chip code: everything goes to the bus
            assign ext = 1'b1;
        end else begin : g_rom
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(INT_ROM_BYTES);
            assign ext = !ea_pin || ({1'b0, addr} >= LIMIT);
        end
    endgenerate

endmodule

// File: rtl/xfs_capture.sv
module xfs_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take)
                dout <= din;
        end
    end

    // R9: a capture pulse never lasts two clocks
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R9: the byte only changes together with its pulse
    a_r9_byte_held: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(dout));

endmodule

// File: rtl/xfs_fetch_seq.sv
module xfs_fetch_seq #(
    parameter int CYCLE_LEN     = 12,
    parameter int SLOTS         = 2,
    parameter int LATCH_LEN     = 2,
    parameter int HOLD_LEN      = 1,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ea_pin,
    input  logic [15:0] fetch_addr,
    input  logic        fetch_req,
    input  logic [7:0]  port_lo_in,
    output logic        ale,
    output logic        psen_n,
    output logic [7:0]  port_lo_out,
    output logic        port_lo_oe,
    output logic [7:0]  port_hi_out,
    output logic [7:0]  code_byte,
    output logic        code_valid
);
    import xfs_pkg::*;

    localparam int SLOT_LEN = CYCLE_LEN / SLOTS;
    localparam int SUB_W    = $clog2(SLOT_LEN);
    localparam int HALF_W   = ADDR_W / 2;

    logic [SUB_W-1:0] sub;
    logic             slot_end;
    logic             addr_ext;
    slot_t            slot_q;
    slot_phase_e      phase;

    xfs_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .sub      (sub),
        .slot_end (slot_end)
    );

    xfs_route #(.ADDR_W(ADDR_W), .INT_ROM_BYTES(INT_ROM_BYTES)) u_route (
        .ea_pin (ea_pin),
        .addr   (fetch_addr),
        .ext    (addr_ext)
    );

    // Next slot's job is decided in the last period of the current one
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (slot_end) begin
            slot_q.ext  <= fetch_req && addr_ext;
            slot_q.addr <= fetch_addr;
        end
    end

    assign phase = phase_of(32'(sub), LATCH_LEN, HOLD_LEN);

    // Strobes and port drive are decoded only from registered state
    always_comb begin
        ale         = 1'b0;
        psen_n      = 1'b1;
        port_lo_oe  = 1'b0;
        port_lo_out = '1;
        port_hi_out = '1;
        if (slot_q.ext) begin
            ale         = (phase == PH_LATCH);
            psen_n      = (phase != PH_STROBE);
            port_lo_oe  = (phase != PH_STROBE);
            port_lo_out = slot_q.addr[HALF_W-1:0];
            port_hi_out = slot_q.addr[ADDR_W-1:HALF_W];
        end
    end

    xfs_capture #(.BYTE_W(BYTE_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .take  (slot_end && slot_q.ext),
        .din   (port_lo_in),
        .dout  (code_byte),
        .valid (code_valid)
    );

    // R5: the two strobes are never active together
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));

    // R4: the shared port is released whenever memory may drive it
    a_r4_released_in_strobe: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !port_lo_oe);

    // R4: address stays driven for the hold period after the latch strobe falls
    a_r4_hold_after_latch: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (port_lo_oe && $stable(port_lo_out)));

    // R5: a store strobe lasts more than one period
    a_r5_strobe_width: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n);

    // R6: high address does not move while memory is being read
    a_r6_hi_stable: assert property (@(posedge clk) disable iff (rst)
        (!psen_n && !$fell(psen_n)) |-> $stable(port_hi_out));

    // R9: a captured byte always follows a store strobe
    a_r9_after_strobe: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(!psen_n));

endmodule

// File: tb/xfs_fetch_seq_test.sv
module xfs_fetch_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_pin = 1'b1;
    logic [15:0] fetch_addr = 16'h0000;
    logic        fetch_req = 1'b0;
    logic [7:0]  port_lo_in = 8'h00;
    logic        ale, psen_n, port_lo_oe, code_valid;
    logic [7:0]  port_lo_out, port_hi_out, code_byte;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    always #4 clk = ~clk;

    xfs_fetch_seq uut (
        .clk(clk), .rst(rst), .ea_pin(ea_pin), .fetch_addr(fetch_addr),
        .fetch_req(fetch_req), .port_lo_in(port_lo_in), .ale(ale),
        .psen_n(psen_n), .port_lo_out(port_lo_out), .port_lo_oe(port_lo_oe),
        .port_hi_out(port_hi_out), .code_byte(code_byte), .code_valid(code_valid)
    );

    // Expected behaviour, built from the requirements
    int          ph = 0;
    bit          m_ext = 0, m_req = 0, m_ea = 0, m_valid = 0;
    logic [15:0] m_addr = 16'h0;
    logic [7:0]  m_byte = 8'h00;

    function automatic bit goes_off_chip(input bit ea, input logic [15:0] a);
        return !ea || (a > 16'h0FFF);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph <= 0; m_ext <= 0; m_req <= 0; m_valid <= 0; m_addr <= 16'h0; m_byte <= 8'h00;
        end else begin
            ph <= (ph == 5) ? 0 : ph + 1;
            if (ph == 5) begin
                m_ext   <= fetch_req && goes_off_chip(ea_pin, fetch_addr);
                m_req   <= fetch_req;
                m_ea    <= ea_pin;
                m_addr  <= fetch_addr;
                m_valid <= m_ext;
                if (m_ext) m_byte <= port_lo_in;
            end else begin
                m_valid <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Compare every period, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            string sel;
            if (rst)             sel = "R1";
            else if (!m_req)     sel = "R10";
            else if (m_ea && !m_ext) sel = "R7";
            else if (!m_ea)      sel = "R8";
            else                 sel = "R7";
            chk((rst || !m_req) ? sel : (ph == 0 ? "R2" : "R3"), 16'(ale), 16'(m_ext && ph < 2));
            chk(m_ext ? "R5" : sel, 16'(psen_n), 16'(!(m_ext && ph >= 3)));
            chk(m_ext ? "R4" : sel, 16'(port_lo_oe), 16'(m_ext && ph < 3));
            chk(m_ext ? "R4" : sel, 16'(port_lo_out), m_ext ? 16'(m_addr[7:0]) : 16'h00FF);
            chk(m_ext ? "R6" : sel, 16'(port_hi_out), m_ext ? 16'(m_addr[15:8]) : 16'h00FF);
            chk(rst ? "R1" : "R9", 16'(code_valid), 16'(m_valid));
            chk(rst ? "R1" : "R9", 16'(code_byte), 16'(m_byte));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Directed slot list, then random slots
    task automatic pick_slot(input int n);
        case (n)
            0: begin fetch_req = 1; ea_pin = 0; fetch_addr = 16'h1234; end // R2: first slot
            1: begin fetch_req = 0; ea_pin = 0; fetch_addr = 16'h5678; end // R10
            2: begin fetch_req = 1; ea_pin = 1; fetch_addr = 16'h0FFF; end // R7 boundary inside
            3: begin fetch_req = 1; ea_pin = 1; fetch_addr = 16'h1000; end // R7 boundary outside
            4: begin fetch_req = 1; ea_pin = 0; fetch_addr = 16'h0000; end // R8
            5: begin fetch_req = 1; ea_pin = 0; fetch_addr = 16'h0FFF; end // R8
            6: begin fetch_req = 1; ea_pin = 1; fetch_addr = 16'hFFFF; end // R7 top
            7: begin fetch_req = 1; ea_pin = 1; fetch_addr = 16'h0000; end // R7 bottom
            8: begin fetch_req = 1; ea_pin = 1; fetch_addr = 16'hA55A; end // back to back
            default: begin
                fetch_req  = ($urandom % 4) != 0;
                ea_pin     = 1'($urandom);
                fetch_addr = ($urandom % 3 == 0) ? 16'(12'($urandom)) : 16'($urandom);
            end
        endcase
    endtask

    initial begin
        int slot_no;
        void'($urandom(32'd20240611));
        repeat (30) @(negedge clk);                 // R1 checked each period
        pick_slot(0);
        rst = 1'b0;
        slot_no = 1;
        while (slot_no < 420) begin
            @(negedge clk);
            port_lo_in = 8'($urandom);              // R9: only one sample point counts
            if (ph == 5) begin
                pick_slot(slot_no);
                slot_no++;
            end
        end
        repeat (14) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule